// File: doc/BRIEF.md
# Wide-Word Video Frame Encapsulator

This block assembles outgoing 16-bit frames for a serial transceiver running at 125 MHz, one word per clock. It sits after a ping-pong payload merger that has already combined two byte-wide pixel streams into 16-bit words. Each frame starts with four fixed header words whose upper byte is 0x55. Two control words follow; each pairs one control byte from source port A with the matching byte from source port B. Then come 768 payload words pulled from the merger, and the frame closes with six zero words, for 780 words in all.

The merger raises `frame_ready` when a complete payload frame sits in its read bank. The encapsulator then latches the four control bytes and sends the whole frame without gaps. It asks for payload one cycle ahead with `pay_rd`, because the merger's buffer returns a word the cycle after each request. When `frame_ready` is still high on the last word of a frame, the next frame follows with no idle cycle. Between frames the output word is zero and `out_valid` is low.

Top module: `wide_frame_encap`

## Requirements
- R1: During and right after reset, `out_valid` is 0, `out_word` is 0x0000 and `pay_rd` is 0.
- R2: Frame positions 0 to 3 carry 0x557C, 0x55D2, 0x5515 and 0x55D8, in that order.
- R3: Position 4 carries {ctrl_b[7:0], ctrl_a[7:0]} and position 5 carries {ctrl_b[15:8], ctrl_a[15:8]}, so port B is in the upper byte. The bytes are the values sampled on the clock edge that starts the frame; later changes to `ctrl_a` and `ctrl_b` do not alter the frame.
- R4: Positions 6 to 773 carry the merger's words unchanged, in the order they were requested.
- R5: `pay_rd` is high for exactly 768 cycles per frame. Each request's data is expected on `pay_data` one cycle later and appears on `out_word` the cycle after that.
- R6: Positions 774 to 779 are 0x0000, and a frame is 780 consecutive cycles with `out_valid` high.
- R7: When `frame_ready` is sampled high while idle, header word 0 appears on the output one clock after that sampling edge.
- R8: A `frame_ready` pulse during a frame, except on its last word, has no effect: the frame ends after 780 words and the output then stays idle.
- R9: If `frame_ready` is high on the clock edge that ends the last word, the next frame's header follows directly, with `out_valid` staying high.
- R10: While no frame is being sent, `out_valid` is 0 and `out_word` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_ready | input | 1 | Merger has a full payload frame ready |
| ctrl_a | input | 16 | Port A control bytes: [7:0] first, [15:8] second |
| ctrl_b | input | 16 | Port B control bytes: [7:0] first, [15:8] second |
| pay_data | input | 16 | Merged payload word, valid the cycle after `pay_rd` |
| pay_rd | output | 1 | Payload read request |
| out_word | output | 16 | Frame word to the transceiver |
| out_valid | output | 1 | Strobe marking a valid frame word |

## Verification
The assertions assume that the merger returns data exactly one cycle after each `pay_rd` and never stalls. They also assume that `frame_ready` is raised only when the merger truly holds 768 words. The bench's merger model answers every request on the next edge with a known increasing pattern. It raises `frame_ready` only as a deliberate single-cycle pulse or as a level held across a frame boundary, so the checks on trailer content and frame length always see complete frames.

// File: rtl/wfe_pkg.sv
// Package: shared types for the wide-word frame encapsulator.
// Assumes a frame is laid out as header, control, payload and trailer, in that order.
package wfe_pkg;
    typedef enum logic [1:0] {
        SEG_HDR  = 2'd0,
        SEG_CTRL = 2'd1,
        SEG_PAY  = 2'd2,
        SEG_TAIL = 2'd3
    } seg_t;
endpackage

// File: rtl/wfe_sequencer.sv
// Module: wfe_sequencer
// Tracks the position inside the current frame and decodes which segment it is in.
// It issues payload read requests one cycle early.
// Assumes HDR_LEN + CTRL_LEN >= 1, so that the early request lands inside the frame.
module wfe_sequencer
    import wfe_pkg::*;
#(
    parameter int HDR_LEN  = 4,
    parameter int CTRL_LEN = 2,
    parameter int PAY_LEN  = 768,
    parameter int TAIL_LEN = 6,
    parameter int POS_W    = $clog2(HDR_LEN + CTRL_LEN + PAY_LEN + TAIL_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_ready,
    output logic             active,
    output logic             start,
    output seg_t             seg,
    output logic [POS_W-1:0] seg_idx,
    output logic             pay_rd
);
    localparam int FRAME_LEN = HDR_LEN + CTRL_LEN + PAY_LEN + TAIL_LEN;
    localparam int CTRL_BASE = HDR_LEN;
    localparam int PAY_BASE  = HDR_LEN + CTRL_LEN;
    localparam int TAIL_BASE = PAY_BASE + PAY_LEN;

    logic             active_q;
    logic [POS_W-1:0] pos_q;
    logic             last;

    // Detect the final word and decide whether a frame starts this cycle.
    always_comb begin
        last  = active_q && (pos_q == POS_W'(FRAME_LEN - 1));
        start = frame_ready && (!active_q || last);
    end

    // Advance the frame position, restart on demand, or return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            pos_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            pos_q    <= '0;
        end else if (last) begin
            active_q <= 1'b0;
            pos_q    <= '0;
        end else if (active_q) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // Map the position to a segment and an index within that segment.
    always_comb begin
        if (pos_q < POS_W'(CTRL_BASE)) begin
            seg     = SEG_HDR;
            seg_idx = pos_q;
        end else if (pos_q < POS_W'(PAY_BASE)) begin
            seg     = SEG_CTRL;
            seg_idx = pos_q - POS_W'(CTRL_BASE);
        end else if (pos_q < POS_W'(TAIL_BASE)) begin
            seg     = SEG_PAY;
            seg_idx = pos_q - POS_W'(PAY_BASE);
        end else begin
            seg     = SEG_TAIL;
            seg_idx = pos_q - POS_W'(TAIL_BASE);
        end
    end

    // Request payload one position ahead to cover the buffer's read latency.
    always_comb begin
        pay_rd = active_q
              && (pos_q >= POS_W'(PAY_BASE - 1))
              && (pos_q <= POS_W'(TAIL_BASE - 2));
    end

    assign active = active_q;
endmodule

// File: rtl/wfe_ctrl_latch.sv
// Module: wfe_ctrl_latch
// Captures the control bytes of both ports when a frame starts.
// Each output word pairs port B (upper byte) with port A (lower byte).
// Assumes the control inputs are valid on the cycle load is high.
module wfe_ctrl_latch #(
    parameter int BYTE_W   = 8,
    parameter int CTRL_LEN = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [CTRL_LEN*BYTE_W-1:0]   ctrl_a,
    input  logic [CTRL_LEN*BYTE_W-1:0]   ctrl_b,
    output logic [CTRL_LEN*2*BYTE_W-1:0] ctrl_words
);
    for (genvar g = 0; g < CTRL_LEN; g++) begin : g_word
        // Hold one paired control word for the rest of the frame.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_words[g*2*BYTE_W +: 2*BYTE_W] <= '0;
            end else if (load) begin
                ctrl_words[g*2*BYTE_W +: 2*BYTE_W] <=
                    {ctrl_b[g*BYTE_W +: BYTE_W], ctrl_a[g*BYTE_W +: BYTE_W]};
            end
        end
    end
endmodule

// File: rtl/wfe_word_mux.sv
// Module: wfe_word_mux
// Selects the word for the current segment and registers it with its valid strobe.
// Assumes pay_data already holds the word requested in the previous cycle.
module wfe_word_mux
    import wfe_pkg::*;
#(
    parameter int                        WORD_W    = 16,
    parameter int                        HDR_LEN   = 4,
    parameter int                        CTRL_LEN  = 2,
    parameter int                        POS_W     = 10,
    parameter logic [HDR_LEN*WORD_W-1:0] HDR_WORDS = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       active,
    input  seg_t                       seg,
    input  logic [POS_W-1:0]           seg_idx,
    input  logic [CTRL_LEN*WORD_W-1:0] ctrl_words,
    input  logic [WORD_W-1:0]          pay_data,
    output logic [WORD_W-1:0]          out_word,
    output logic                       out_valid
);
    logic [WORD_W-1:0] sel;

    // Pick the source word for the current segment.
    always_comb begin
        sel = '0;
        case (seg)
            SEG_HDR: begin
                for (int i = 0; i < HDR_LEN; i++) begin
                    if (seg_idx == POS_W'(i)) sel = HDR_WORDS[i*WORD_W +: WORD_W];
                end
            end
            SEG_CTRL: begin
                for (int i = 0; i < CTRL_LEN; i++) begin
                    if (seg_idx == POS_W'(i)) sel = ctrl_words[i*WORD_W +: WORD_W];
                end
            end
            SEG_PAY:  sel = pay_data;
            default:  sel = '0;
        endcase
    end

    // Register the output word; it is forced to zero outside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_word  <= active ? sel : '0;
            out_valid <= active;
        end
    end
endmodule

// File: rtl/wide_frame_encap.sv
// Module: wide_frame_encap (top)
// Builds 780-word frames: header, paired control words, merged payload and zero trailer.
// Assumes the merger returns a word one cycle after each pay_rd and never stalls.
module wide_frame_encap #(
    parameter int                        BYTE_W    = 8,
    parameter int                        HDR_LEN   = 4,
    parameter int                        CTRL_LEN  = 2,
    parameter int                        PAY_LEN   = 768,
    parameter int                        TAIL_LEN  = 6,
    parameter logic [HDR_LEN*2*BYTE_W-1:0] HDR_WORDS =
        {16'h55D8, 16'h5515, 16'h55D2, 16'h557C}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_ready,
    input  logic [CTRL_LEN*BYTE_W-1:0] ctrl_a,
    input  logic [CTRL_LEN*BYTE_W-1:0] ctrl_b,
    input  logic [2*BYTE_W-1:0]        pay_data,
    output logic                       pay_rd,
    output logic [2*BYTE_W-1:0]        out_word,
    output logic                       out_valid
);
    import wfe_pkg::*;

    localparam int WORD_W    = 2 * BYTE_W;
    localparam int FRAME_LEN = HDR_LEN + CTRL_LEN + PAY_LEN + TAIL_LEN;
    localparam int POS_W     = $clog2(FRAME_LEN);

    logic                       active;
    logic                       start;
    seg_t                       seg;
    logic [POS_W-1:0]           seg_idx;
    logic [CTRL_LEN*WORD_W-1:0] ctrl_words;

    wfe_sequencer #(
        .HDR_LEN (HDR_LEN),
        .CTRL_LEN(CTRL_LEN),
        .PAY_LEN (PAY_LEN),
        .TAIL_LEN(TAIL_LEN),
        .POS_W   (POS_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_ready(frame_ready),
        .active     (active),
        .start      (start),
        .seg        (seg),
        .seg_idx    (seg_idx),
        .pay_rd     (pay_rd)
    );

    wfe_ctrl_latch #(
        .BYTE_W  (BYTE_W),
        .CTRL_LEN(CTRL_LEN)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .ctrl_a    (ctrl_a),
        .ctrl_b    (ctrl_b),
        .ctrl_words(ctrl_words)
    );

    wfe_word_mux #(
        .WORD_W   (WORD_W),
        .HDR_LEN  (HDR_LEN),
        .CTRL_LEN (CTRL_LEN),
        .POS_W    (POS_W),
        .HDR_WORDS(HDR_WORDS)
    ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .seg       (seg),
        .seg_idx   (seg_idx),
        .ctrl_words(ctrl_words),
        .pay_data  (pay_data),
        .out_word  (out_word),
        .out_valid (out_valid)
    );
endmodule

// File: rtl/wfe_checker.sv
// Module: wfe_checker
// Checks frame timing and content at the top-level ports.
// Assumes the default frame layout and a merger with a one-cycle read latency.
module wfe_checker #(
    parameter int          FRAME_LEN = 780,
    parameter int          TAIL_LEN  = 6,
    parameter int          WORD_W    = 16,
    parameter logic [15:0] HDR0      = 16'h557C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pay_rd,
    input logic [WORD_W-1:0] out_word,
    input logic              out_valid
);
    localparam int CNT_W = $clog2(FRAME_LEN);

    logic [CNT_W-1:0] cnt;

    // Count the words of the current frame from the output strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cnt <= '0;
        else if (!out_valid)                     cnt <= '0;
        else if (cnt == CNT_W'(FRAME_LEN - 1))   cnt <= '0;
        else                                     cnt <= cnt + 1'b1;
    end

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_word == '0));

    a_r5_rd_feeds_word: assert property (@(posedge clk) disable iff (!rst_n)
        pay_rd |=> ##1 out_valid);

    a_r2_first_header: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cnt == '0) |-> (out_word == HDR0[WORD_W-1:0]));

    a_r6_trailer_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cnt >= CNT_W'(FRAME_LEN - TAIL_LEN)) |-> (out_word == '0));

    a_r6_full_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> ($past(cnt) == CNT_W'(FRAME_LEN - 1)));
endmodule

bind wide_frame_encap wfe_checker u_wfe_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .pay_rd   (pay_rd),
    .out_word (out_word),
    .out_valid(out_valid)
);

// File: tb/test_wide_frame_encap.sv
`timescale 1ns/1ps
module test_wide_frame_encap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_ready = 1'b0;
    logic [15:0] ctrl_a = '0;
    logic [15:0] ctrl_b = '0;
    logic [15:0] pay_data = '0;
    logic        pay_rd;
    logic [15:0] out_word;
    logic        out_valid;

    int          n_checks = 0;
    int          n_fails  = 0;
    int          rd_idx   = 0;
    logic [15:0] pay_seed = '0;
    logic [15:0] words [0:1599];

    always #5 clk = ~clk;

    wide_frame_encap i_wide_frame_encap (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_ready(frame_ready),
        .ctrl_a     (ctrl_a),
        .ctrl_b     (ctrl_b),
        .pay_data   (pay_data),
        .pay_rd     (pay_rd),
        .out_word   (out_word),
        .out_valid  (out_valid)
    );

    // Merger model: answers each request on the next edge with seed + index.
    always @(posedge clk) begin
        if (pay_rd) begin
            pay_data <= pay_seed + 16'(rd_idx);
            rd_idx   <= rd_idx + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        check(out_word == 16'h0, "R1 word", int'(out_word), 0);
        check(pay_rd == 1'b0, "R1 pay_rd", int'(pay_rd), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_word == 16'h0, "R10 idle after reset", int'(out_word), 0);
    endtask

    // One frame with a one-cycle ready pulse; control inputs change right after the start.
    task automatic t_frame(input logic [15:0] ca, input logic [15:0] cb,
                           input logic [15:0] seed, input bit mid_pulse);
        int n_valid = 0;
        int bad = 0;
        int first_bad = 0;
        bit idle_ok = 1'b1;
        @(negedge clk);
        ctrl_a = ca; ctrl_b = cb; pay_seed = seed; rd_idx = 0; frame_ready = 1'b1;
        @(negedge clk);
        frame_ready = 1'b0; ctrl_a = ~ca; ctrl_b = ~cb;
        @(negedge clk);
        check(out_valid == 1'b1, "R7 start latency", int'(out_valid), 1);
        for (int k = 0; k < 780; k++) begin
            if (mid_pulse && k == 100) frame_ready = 1'b1;
            if (mid_pulse && k == 101) frame_ready = 1'b0;
            words[k] = out_word;
            if (out_valid) n_valid++;
            @(negedge clk);
        end
        check(words[0] == 16'h557C, "R2 hdr0", int'(words[0]), 'h557C);
        check(words[1] == 16'h55D2, "R2 hdr1", int'(words[1]), 'h55D2);
        check(words[2] == 16'h5515, "R2 hdr2", int'(words[2]), 'h5515);
        check(words[3] == 16'h55D8, "R2 hdr3", int'(words[3]), 'h55D8);
        check(words[4] == {cb[7:0], ca[7:0]}, "R3 ctrl word 0", int'(words[4]), int'({cb[7:0], ca[7:0]}));
        check(words[5] == {cb[15:8], ca[15:8]}, "R3 ctrl word 1", int'(words[5]), int'({cb[15:8], ca[15:8]}));
        for (int i = 0; i < 768; i++) begin
            if (words[6+i] != 16'(seed + 16'(i))) begin
                if (bad == 0) first_bad = i;
                bad++;
            end
        end
        check(bad == 0, "R4 payload mismatches", bad, 0);
        if (bad != 0)
            $display("  first mismatch at payload index %0d: 0x%0h", first_bad, words[6+first_bad]);
        bad = 0;
        for (int i = 774; i < 780; i++) if (words[i] != 16'h0) bad++;
        check(bad == 0, "R6 trailer nonzero words", bad, 0);
        check(n_valid == 780, "R6 frame length", n_valid, 780);
        check(rd_idx == 768, "R5 read requests", rd_idx, 768);
        for (int i = 0; i < 10; i++) begin
            if (out_valid || out_word != 16'h0) idle_ok = 1'b0;
            @(negedge clk);
        end
        check(idle_ok, mid_pulse ? "R8 mid-frame ready ignored" : "R10 idle output",
              int'(idle_ok), 1);
    endtask

    // Ready held across the boundary: two frames follow without a gap.
    task automatic t_back_to_back(input logic [15:0] ca, input logic [15:0] cb,
                                  input logic [15:0] seed);
        int n = 0;
        int bad = 0;
        @(negedge clk);
        ctrl_a = ca; ctrl_b = cb; pay_seed = seed; rd_idx = 0; frame_ready = 1'b1;
        while (!out_valid) @(negedge clk);
        while (out_valid && n < 1600) begin
            words[n] = out_word;
            n++;
            if (n == 800) frame_ready = 1'b0;
            @(negedge clk);
        end
        check(n == 1560, "R9 contiguous run", n, 1560);
        check(words[780] == 16'h557C, "R9 second header", int'(words[780]), 'h557C);
        check(words[784] == {cb[7:0], ca[7:0]}, "R3 second frame ctrl", int'(words[784]), int'({cb[7:0], ca[7:0]}));
        for (int i = 0; i < 768; i++)
            if (words[786+i] != 16'(seed + 16'(768 + i))) bad++;
        check(bad == 0, "R4 second frame payload", bad, 0);
        check(rd_idx == 1536, "R5 reads over two frames", rd_idx, 1536);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_frame({8'h34, 8'h00}, {8'h35, 8'h00}, 16'h0000, 1'b0);
        t_frame({8'h12, 8'hA5}, {8'h9C, 8'h3E}, 16'h4321, 1'b1);
        t_back_to_back({8'h77, 8'h01}, {8'h78, 8'h02}, 16'hF000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule